// File: doc/BRIEF.md
# DMA Channel Address/Count Sequencer

A single-channel transfer engine for a legacy-style DMA controller. Software loads a base address, a base count and mode bits through an external register file and then pulses a load strobe. Each completed transfer cycle then steps the 16-bit current address up or down by one and the 16-bit current count down by one. The count is programmed as the number of transfers minus one. Terminal count is the cycle whose count is zero; stepping from there leaves the count at all ones.

The channel requests the bus with a request output when its device asserts a request input, waits for the bus grant, drives the acknowledge for exactly one transfer cycle and then releases the request (single-transfer mode). The full physical address is formed from a page value and the current address. A byte channel appends the address to the page. A word channel shifts the address left by one and ignores the page LSB. The page never advances, so a run wraps inside its region. In cascade mode the channel only passes the device request up and the grant back down.

The register file reads back the current values, the mask and a sticky terminal-count status bit. Arbitration among several channels is done elsewhere.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset hrq_o, dack_o, done_o and tc_o are 0, mask_o is 1, tc_sts_o is 0, and cur_addr_o and cur_cnt_o are 0.
- R2: A cycle with load_i high copies base_addr_i and base_cnt_i into cur_addr_o and cur_cnt_o at the next edge and clears tc_sts_o.
- R3: Outside cascade mode, an unmasked dreq_i seen in the idle state raises hrq_o one cycle later. hlda_i while hrq_o is high raises dack_o and done_o for exactly one cycle on the next cycle. hrq_o is low on the cycle after dack_o.
- R4: Each transfer decrements cur_cnt_o by one. A loaded count of N gives N+1 transfers, where a count of 0x0000 gives one transfer. After the final transfer cur_cnt_o reads 0xFFFF.
- R5: Each transfer adds one to cur_addr_o when incr_i is 1 and subtracts one when incr_i is 0. The address wraps modulo 2^16 and page_i is never altered.
- R6: With WORD_CHAN=0, phys_addr_o = {page_i, cur_addr_o}.
- R7: With WORD_CHAN=1, phys_addr_o = {page_i[7:1], cur_addr_o, 1'b0}, so page bit 0 has no effect.
- R8: tc_o is high together with done_o on the transfer whose count is 0. Every terminal count sets tc_sts_o. Without auto-initialise it also sets mask_o.
- R9: With autoinit_i set, terminal count reloads cur_addr_o and cur_cnt_o from the base values and leaves mask_o unchanged.
- R10: With cascade_i set, hrq_o equals dreq_i while unmasked and dack_o equals hlda_i. done_o stays 0, and the current address and count do not change.
- R11: While mask_o is 1, dreq_i does not raise hrq_o.
- R12: A cycle with mask_wr_i high writes mask_wdata_i into mask_o, and this takes precedence over a terminal-count set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Copy base values into current registers |
| base_addr_i | input | 16 | Base address |
| base_cnt_i | input | 16 | Base count (transfers minus one) |
| page_i | input | 8 | Page value, upper physical address bits |
| incr_i | input | 1 | 1: address increments, 0: decrements |
| autoinit_i | input | 1 | Reload from base on terminal count |
| cascade_i | input | 1 | Pass-through mode |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 1 | Mask write value |
| dreq_i | input | 1 | Device request |
| hlda_i | input | 1 | Bus grant |
| hrq_o | output | 1 | Bus request |
| dack_o | output | 1 | Device acknowledge |
| done_o | output | 1 | Transfer cycle completes this cycle |
| tc_o | output | 1 | Terminal count on this transfer |
| cur_addr_o | output | 16 | Current address |
| cur_cnt_o | output | 16 | Current count |
| phys_addr_o | output | 24 | Physical bus address |
| mask_o | output | 1 | Channel mask |
| tc_sts_o | output | 1 | Sticky terminal-count status |

## Verification
The hardest state to reach is terminal count, because it needs a complete run of handshakes. Three other states need the same: the auto-initialise reload, the address wrap through zero, and the zero-count single transfer. The bench drives short runs. Each handshake completes in three cycles with the grant held high, and the counts are chosen so that the wrap and the reload fall within a few transfers. A byte instance and a word instance receive the same stimulus so that both address maps are compared on every clock.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } hs_state_e;
endpackage

// File: rtl/dma_hs_fsm.sv
module dma_hs_fsm
  import dma_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cascade_i,
  input  logic mask_i,
  input  logic dreq_i,
  input  logic hlda_i,
  output logic hrq_o,
  output logic dack_o,
  output logic done_o
);
  hs_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (dreq_i && !mask_i) st_d = ST_REQ;
      ST_REQ:  if (hlda_i) st_d = ST_XFER;
      ST_XFER: st_d = ST_IDLE;  // single mode: release after each transfer
      default: st_d = ST_IDLE;
    endcase
    if (cascade_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;

  always_comb begin
    if (cascade_i) begin
      hrq_o  = dreq_i & ~mask_i;
      dack_o = hlda_i;
      done_o = 1'b0;
    end else begin
      hrq_o  = (st_q != ST_IDLE);
      dack_o = (st_q == ST_XFER);
      done_o = (st_q == ST_XFER);
    end
  end
endmodule

// File: rtl/dma_cur_regs.sv
module dma_cur_regs #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  base_cnt_i,
  input  logic              incr_i,
  input  logic              autoinit_i,
  input  logic              mask_wr_i,
  input  logic              mask_wdata_i,
  input  logic              done_i,
  output logic              tc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              mask_o,
  output logic              tc_sts_o
);
  logic [ADDR_W-1:0] addr_step;

  assign tc_o      = done_i && (cnt_o == '0);
  assign addr_step = incr_i ? addr_o + ADDR_W'(1) : addr_o - ADDR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      cnt_o    <= '0;
      tc_sts_o <= 1'b0;
    end else if (load_i) begin
      addr_o   <= base_addr_i;
      cnt_o    <= base_cnt_i;
      tc_sts_o <= 1'b0;
    end else if (done_i) begin
      if (tc_o) tc_sts_o <= 1'b1;
      if (tc_o && autoinit_i) begin
        addr_o <= base_addr_i;
        cnt_o  <= base_cnt_i;
      end else begin
        addr_o <= addr_step;
        cnt_o  <= cnt_o - CNT_W'(1);  // 0 wraps to all ones
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    mask_o <= 1'b1;
    else if (mask_wr_i)             mask_o <= mask_wdata_i;
    else if (tc_o && !autoinit_i)   mask_o <= 1'b1;
  end
endmodule

// File: rtl/dma_phys_map.sv
module dma_phys_map #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_W    = 8,
  parameter bit WORD_CHAN = 1'b0,
  localparam int PHYS_W   = ADDR_W + PAGE_W
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [PHYS_W-1:0] phys_o
);
  generate
    if (WORD_CHAN) begin : g_word
      logic unused_pg0;
      assign unused_pg0 = page_i[0];
      assign phys_o = {page_i[PAGE_W-1:1], addr_i, 1'b0};
    end else begin : g_byte
      assign phys_o = {page_i, addr_i};
    end
  endgenerate
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int PAGE_W    = 8,
  parameter bit WORD_CHAN = 1'b0,
  localparam int PHYS_W   = ADDR_W + PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  base_cnt_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              incr_i,
  input  logic              autoinit_i,
  input  logic              cascade_i,
  input  logic              mask_wr_i,
  input  logic              mask_wdata_i,
  input  logic              dreq_i,
  input  logic              hlda_i,
  output logic              hrq_o,
  output logic              dack_o,
  output logic              done_o,
  output logic              tc_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [CNT_W-1:0]  cur_cnt_o,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic              mask_o,
  output logic              tc_sts_o
);
  dma_hs_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cascade_i(cascade_i),
    .mask_i   (mask_o),
    .dreq_i   (dreq_i),
    .hlda_i   (hlda_i),
    .hrq_o    (hrq_o),
    .dack_o   (dack_o),
    .done_o   (done_o)
  );

  dma_cur_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .base_addr_i (base_addr_i),
    .base_cnt_i  (base_cnt_i),
    .incr_i      (incr_i),
    .autoinit_i  (autoinit_i),
    .mask_wr_i   (mask_wr_i),
    .mask_wdata_i(mask_wdata_i),
    .done_i      (done_o),
    .tc_o        (tc_o),
    .addr_o      (cur_addr_o),
    .cnt_o       (cur_cnt_o),
    .mask_o      (mask_o),
    .tc_sts_o    (tc_sts_o)
  );

  dma_phys_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WORD_CHAN(WORD_CHAN)) u_map (
    .page_i(page_i),
    .addr_i(cur_addr_o),
    .phys_o(phys_addr_o)
  );
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [CNT_W-1:0]  base_cnt_i,
  input logic              autoinit_i,
  input logic              cascade_i,
  input logic              mask_wr_i,
  input logic              hlda_i,
  input logic              hrq_o,
  input logic              dack_o,
  input logic              done_o,
  input logic              tc_o,
  input logic [ADDR_W-1:0] cur_addr_o,
  input logic [CNT_W-1:0]  cur_cnt_o,
  input logic              mask_o,
  input logic              tc_sts_o
);
  AST_DACK_AFTER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cascade_i && dack_o) |-> $past(hlda_i) && $past(hrq_o)); // R3
  AST_SINGLE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cascade_i && dack_o) |=> (!hrq_o || cascade_i)); // R3
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !tc_o && !load_i) |=> cur_cnt_o == $past(cur_cnt_o) - CNT_W'(1)); // R4
  AST_TC_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !autoinit_i && !mask_wr_i && !load_i) |=> (mask_o && tc_sts_o)); // R8
  AST_AUTO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && autoinit_i && !load_i) |=> cur_cnt_o == $past(base_cnt_i)); // R9
  AST_CASCADE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cascade_i && $past(cascade_i) && !$past(load_i)) |-> ($stable(cur_cnt_o) && $stable(cur_addr_o) && !done_o)); // R10
  AST_MASK_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hrq_o) && !cascade_i) |-> !$past(mask_o)); // R11
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
  logic clk = 0, rst_n = 0;
  logic load = 0, incr = 1, autoinit = 0, cascade = 0, mask_wr = 0, mask_wdata = 0;
  logic dreq = 0, hlda = 1;
  logic [15:0] base_addr = 0, base_cnt = 0;
  logic [7:0] page = 8'h12;
  logic hrq, dack, done, tc, mask, tc_sts;
  logic [15:0] cur_addr, cur_cnt;
  logic [23:0] phys;
  logic hrq_w, dack_w, done_w, tc_w, mask_w, tc_sts_w;
  logic [15:0] cur_addr_w, cur_cnt_w;
  logic [23:0] phys_w;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_st, m_addr, m_cnt, m_mask, m_sts;
  bit m_done, m_tc, tc_seen;

  always #5 clk = ~clk;

  dma_chan_seq #(.WORD_CHAN(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .base_addr_i(base_addr), .base_cnt_i(base_cnt),
    .page_i(page), .incr_i(incr), .autoinit_i(autoinit), .cascade_i(cascade),
    .mask_wr_i(mask_wr), .mask_wdata_i(mask_wdata), .dreq_i(dreq), .hlda_i(hlda),
    .hrq_o(hrq), .dack_o(dack), .done_o(done), .tc_o(tc), .cur_addr_o(cur_addr),
    .cur_cnt_o(cur_cnt), .phys_addr_o(phys), .mask_o(mask), .tc_sts_o(tc_sts));

  dma_chan_seq #(.WORD_CHAN(1'b1)) uut_w (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .base_addr_i(base_addr), .base_cnt_i(base_cnt),
    .page_i(page), .incr_i(incr), .autoinit_i(autoinit), .cascade_i(cascade),
    .mask_wr_i(mask_wr), .mask_wdata_i(mask_wdata), .dreq_i(dreq), .hlda_i(hlda),
    .hrq_o(hrq_w), .dack_o(dack_w), .done_o(done_w), .tc_o(tc_w), .cur_addr_o(cur_addr_w),
    .cur_cnt_o(cur_cnt_w), .phys_addr_o(phys_w), .mask_o(mask_w), .tc_sts_o(tc_sts_w));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_addr = 0; m_cnt = 0; m_mask = 1; m_sts = 0;
    end else begin
      m_done = !cascade && m_st == 2;
      m_tc   = m_done && m_cnt == 0;
      if (load) begin
        m_addr = base_addr; m_cnt = base_cnt; m_sts = 0;
      end else if (m_done) begin
        if (m_tc) m_sts = 1;
        if (m_tc && autoinit) begin
          m_addr = base_addr; m_cnt = base_cnt;
        end else begin
          m_addr = (incr ? m_addr + 1 : m_addr - 1) & 32'hFFFF;
          m_cnt  = (m_cnt - 1) & 32'hFFFF;
        end
      end
      if (mask_wr) m_mask = mask_wdata;
      else if (m_tc && !autoinit) m_mask = 1;
      if (cascade) m_st = 0;
      else if (m_st == 0) m_st = (dreq && !m_mask) ? 1 : 0;
      else if (m_st == 1) m_st = hlda ? 2 : 1;
      else m_st = 0;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R3 hrq", hrq, cascade ? (dreq & !m_mask[0]) : (m_st != 0));
      chk("R3 dack", dack, cascade ? hlda : (m_st == 2));
      chk("R3 done", done, !cascade && m_st == 2);
      chk("R8 tc", tc, !cascade && m_st == 2 && m_cnt == 0);
      chk("R4 cnt", cur_cnt, m_cnt);
      chk("R5 addr", cur_addr, m_addr);
      chk("R8 mask", mask, m_mask);
      chk("R8 tc_sts", tc_sts, m_sts);
      chk("R6 phys", phys, (page << 16) | m_addr);
      chk("R7 phys_w", phys_w, ((page >> 1) << 17) | (m_addr << 1));
      chk("R7 cnt_w", cur_cnt_w, m_cnt);
    end
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic load_base(input logic [15:0] a, input logic [15:0] c);
    base_addr = a; base_cnt = c; load = 1; step(); load = 0;
  endtask

  task automatic set_mask(input logic v);
    mask_wr = 1; mask_wdata = v; step(); mask_wr = 0;
  endtask

  task automatic one_xfer();
    dreq = 1; tc_seen = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (dack) begin
        tc_seen = tc;
        break;
      end
    end
    dreq = 0; step();
  endtask

  initial begin
    step(); step();
    chk("R1 hrq", hrq, 0); chk("R1 dack", dack, 0); chk("R1 mask", mask, 1);
    chk("R1 tc_sts", tc_sts, 0); chk("R1 cnt", cur_cnt, 0); chk("R1 addr", cur_addr, 0);
    rst_n = 1; step();

    set_mask(0); chk("R12 mask clear", mask, 0);
    load_base(16'h1234, 16'd2); step();
    chk("R2 addr", cur_addr, 16'h1234); chk("R2 cnt", cur_cnt, 16'd2);
    one_xfer(); one_xfer(); chk("R8 no early tc", tc_seen, 0); one_xfer();
    chk("R8 tc pulse", tc_seen, 1);
    chk("R4 final cnt", cur_cnt, 16'hFFFF); chk("R5 incr addr", cur_addr, 16'h1237);
    chk("R8 mask set", mask, 1); chk("R8 sts set", tc_sts, 1);
    chk("R6 phys", phys, 24'h121237);

    dreq = 1;
    for (int i = 0; i < 6; i++) begin step(); chk("R11 masked", hrq, 0); end
    dreq = 0; step();

    incr = 0; load_base(16'h0001, 16'd3); set_mask(0);
    chk("R2 sts clear", tc_sts, 0);
    for (int i = 0; i < 4; i++) one_xfer();
    chk("R5 wrap addr", cur_addr, 16'hFFFD); chk("R5 page fixed", phys, 24'h12FFFD);

    autoinit = 1; load_base(16'h0100, 16'd1); set_mask(0);
    one_xfer(); one_xfer();
    chk("R9 reload addr", cur_addr, 16'h0100); chk("R9 reload cnt", cur_cnt, 16'd1);
    chk("R9 mask kept", mask, 0); chk("R9 sts", tc_sts, 1);
    one_xfer(); chk("R9 runs on", cur_addr, 16'h00FF);

    autoinit = 0; incr = 1; load_base(16'h00FF, 16'd0);
    one_xfer(); chk("R4 single xfer tc", tc_seen, 1);
    chk("R4 zero cnt", cur_cnt, 16'hFFFF); chk("R5 addr", cur_addr, 16'h0100);

    set_mask(0); cascade = 1; hlda = 0; dreq = 1; step();
    chk("R10 hrq pass", hrq, 1); chk("R10 dack", dack, 0);
    hlda = 1; step(); step();
    chk("R10 dack pass", dack, 1); chk("R10 no done", done, 0);
    chk("R10 cnt frozen", cur_cnt, 16'hFFFF); chk("R10 addr frozen", cur_addr, 16'h0100);
    dreq = 0; step(); cascade = 0; step();

    set_mask(1); chk("R12 mask set", mask, 1);

    page = 8'h35; load_base(16'h8001, 16'd5); step();
    chk("R7 word map", phys_w, 24'h350002); chk("R6 byte map", phys, 24'h358001);
    page = 8'h34; step(); chk("R7 page lsb ignored", phys_w, 24'h350002);

    step();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule